// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

A purely combinational 16-bit binary adder. It takes two operands and a carry-in, and returns a 16-bit sum and a carry-out. The operands are cut into four 4-bit slices. Each slice forms per-bit generate (`a & b`) and propagate (`a | b`) terms. It then derives every internal carry as a flat sum-of-products from its slice carry-in, and it summarises itself as one slice generate term and one slice propagate term.

A second lookahead stage has the same shape as the slice stage. It takes the four slice summaries together with the adder carry-in. From them it produces the carry into every slice, each as a single sum-of-products rooted at the carry-in, so no carry ripples from one slice to the next. The second stage also exposes a block-wide generate and propagate pair. A wider adder can therefore put this block under a third lookahead level.

The slice width and slice count are parameters. The defaults give 4 x 4 = 16 bits.

Top module: `cla_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + c0_i`, taken as unsigned integers, in the same evaluation as the inputs change.
- R2: `carry_o` equals bit 16 of `a_i + b_i + c0_i`.
- R3: `prop_o` is 1 exactly when every bit position has `a_i[k] | b_i[k]` equal to 1. This is the OR form of propagate.
- R4: `gen_o` is 1 exactly when `a_i + b_i` with carry-in 0 reaches 2^16.
- R5: `carry_o` always equals `gen_o | (prop_o & c0_i)`, so the block can be nested under a further lookahead level.
- R6: A carry entering at bit 0 passes through all 16 positions. With `a_i = 0xFFFF`, `b_i = 0x0000` and `c0_i = 1`, or with `a_i = 0xFFFF`, `b_i = 0x0001` and `c0_i = 0`, the outputs are `sum_o = 0x0000` and `carry_o = 1`.
- R7: A carry made in one 4-bit slice reaches the following slices across slice boundaries. For example, `0x0FFF + 0x0001` gives `0x1000`, `0x00FF + 0x0001` gives `0x0100`, and `0x7FFF + 0x0001` gives `0x8000`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| c0_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| carry_o | output | 1 | Carry out of bit 15 |
| prop_o | output | 1 | Block-wide propagate term |
| gen_o | output | 1 | Block-wide generate term |

## Verification
The first pattern is all zeros, which shows that no carry or propagate term is asserted without cause. Long propagate chains (`0xFFFF` plus a single carry from either `b_i` or `c0_i`) tell a correct second-level carry apart from one that drops a term of the group sum-of-products. Patterns that cross each slice boundary (`0x000F`, `0x00FF`, `0x0FFF`, `0x7FFF` plus one) isolate a fault in the carry into any single slice. Several thousand random operand pairs with random carry-in then exercise mixed generate and kill positions, where the block-wide generate and propagate outputs differ from the carry-out.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned SLICE_W_DEF  = 4;
  localparam int unsigned SLICE_N_DEF  = 4;

  typedef struct packed {
    logic gen;
    logic prop;
  } pg_t;
endpackage

// File: rtl/cla_pg_bits.sv
module cla_pg_bits
  import cla_pkg::*;
#(
  parameter int unsigned W = SLICE_W_DEF
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output pg_t  [W-1:0] pg_o
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    assign pg_o[k].gen  = a_i[k] & b_i[k];
    assign pg_o[k].prop = a_i[k] | b_i[k];
  end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] g_i,
  input  logic [N-1:0] p_i,
  input  logic         cin_i,
  output logic [N-1:0] c_o,      // c_o[k]: carry out of position k
  output logic         grp_g_o,
  output logic         grp_p_o
);
  // flat sum-of-products per carry, no chained terms
  always_comb begin
    logic acc;
    logic term;
    c_o = '0;
    for (int k = 0; k < N; k++) begin
      acc = cin_i;
      for (int m = 0; m <= k; m++) acc = acc & p_i[m];
      for (int j = 0; j <= k; j++) begin
        term = g_i[j];
        for (int m = j + 1; m <= k; m++) term = term & p_i[m];
        acc = acc | term;
      end
      c_o[k] = acc;
    end
  end

  always_comb begin
    logic acc;
    logic term;
    acc = 1'b0;
    for (int j = 0; j < N; j++) begin
      term = g_i[j];
      for (int m = j + 1; m < N; m++) term = term & p_i[m];
      acc = acc | term;
    end
    grp_g_o = acc;
    grp_p_o = &p_i;
  end

  always_comb begin
    // R5
    cout_gp_chk: assert (c_o[N-1] == (grp_g_o | (grp_p_o & cin_i)));
    // R4
    gen_forces_chk: assert (!grp_g_o || c_o[N-1]);
    // R1
    kill_chk: assert (!(g_i == '0 && !cin_i) || c_o == '0);
  end
endmodule

// File: rtl/cla_slice.sv
module cla_slice
  import cla_pkg::*;
#(
  parameter int unsigned W = SLICE_W_DEF
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         grp_g_o,
  output logic         grp_p_o
);
  pg_t  [W-1:0] pg;
  logic [W-1:0] g_vec;
  logic [W-1:0] p_vec;
  logic [W-1:0] cout;
  logic [W-1:0] cin_vec;

  cla_pg_bits #(.W(W)) u_pg (
    .a_i  (a_i),
    .b_i  (b_i),
    .pg_o (pg)
  );

  for (genvar k = 0; k < W; k++) begin : g_unpack
    assign g_vec[k] = pg[k].gen;
    assign p_vec[k] = pg[k].prop;
    if (k == 0) begin : g_first
      assign cin_vec[k] = cin_i;
    end else begin : g_rest
      assign cin_vec[k] = cout[k-1];
    end
  end

  cla_lookahead #(.N(W)) u_la (
    .g_i     (g_vec),
    .p_i     (p_vec),
    .cin_i   (cin_i),
    .c_o     (cout),
    .grp_g_o (grp_g_o),
    .grp_p_o (grp_p_o)
  );

  assign sum_o = a_i ^ b_i ^ cin_vec;

  always_comb begin
    // R1
    slice_sum_chk: assert ({cout[W-1], sum_o} ==
                           ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}));
  end
endmodule

// File: rtl/cla_adder.sv
module cla_adder
  import cla_pkg::*;
#(
  parameter int unsigned SLICE_W = SLICE_W_DEF,
  parameter int unsigned SLICE_N = SLICE_N_DEF,
  localparam int unsigned W      = SLICE_W * SLICE_N
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c0_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         prop_o,
  output logic         gen_o
);
  logic [SLICE_N-1:0] sl_g;
  logic [SLICE_N-1:0] sl_p;
  logic [SLICE_N-1:0] sl_cout;
  logic [SLICE_N-1:0] sl_cin;

  for (genvar s = 0; s < SLICE_N; s++) begin : g_slice
    if (s == 0) begin : g_first
      assign sl_cin[s] = c0_i;
    end else begin : g_rest
      assign sl_cin[s] = sl_cout[s-1];
    end

    cla_slice #(.W(SLICE_W)) u_slice (
      .a_i     (a_i[s*SLICE_W +: SLICE_W]),
      .b_i     (b_i[s*SLICE_W +: SLICE_W]),
      .cin_i   (sl_cin[s]),
      .sum_o   (sum_o[s*SLICE_W +: SLICE_W]),
      .grp_g_o (sl_g[s]),
      .grp_p_o (sl_p[s])
    );
  end

  // second level: slice carries all rooted at c0_i
  cla_lookahead #(.N(SLICE_N)) u_top_la (
    .g_i     (sl_g),
    .p_i     (sl_p),
    .cin_i   (c0_i),
    .c_o     (sl_cout),
    .grp_g_o (gen_o),
    .grp_p_o (prop_o)
  );

  assign carry_o = sl_cout[SLICE_N-1];

  always_comb begin
    // R1
    add_result_chk: assert ({carry_o, sum_o} ==
                            ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, c0_i}));
    // R3
    prop_all_chk: assert (prop_o == &(a_i | b_i));
    // R4
    gen_nocin_chk: assert (gen_o == (({1'b0, a_i} + {1'b0, b_i}) >> W));
  end
endmodule

// File: tb/sim_cla_adder.sv
module sim_cla_adder;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] a, b, sum;
  logic c0, carry, prop, gen;

  cla_adder u0 (
    .a_i     (a),
    .b_i     (b),
    .c0_i    (c0),
    .sum_o   (sum),
    .carry_o (carry),
    .prop_o  (prop),
    .gen_o   (gen)
  );

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         c0;
    logic [W-1:0] sum;
    logic         carry;
    logic         prop;
    logic         gen;
    string        tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic drive(input logic [W-1:0] av, input logic [W-1:0] bv,
                       input logic cv, input string tag);
    item_t it;
    logic [W:0] full;
    @(negedge clk);
    a = av; b = bv; c0 = cv;
    full = {1'b0, av} + {1'b0, bv} + {{W{1'b0}}, cv};
    it.a = av; it.b = bv; it.c0 = cv;
    it.sum = full[W-1:0];
    it.carry = full[W];
    it.prop = &(av | bv);
    it.gen = (({1'b0, av} + {1'b0, bv}) >> W) != 0;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic cmp(input string req, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] actual=%h expected=%h", req, tag, act, exp);
    end
  endtask

  // monitor: outputs settled half a cycle after drive
  always @(posedge clk) begin
    if (rst_ni && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      cmp("R1", it.tag, sum, it.sum);
      cmp("R2", it.tag, {{(W-1){1'b0}}, carry}, {{(W-1){1'b0}}, it.carry});
      cmp("R3", it.tag, {{(W-1){1'b0}}, prop}, {{(W-1){1'b0}}, it.prop});
      cmp("R4", it.tag, {{(W-1){1'b0}}, gen}, {{(W-1){1'b0}}, it.gen});
      cmp("R5", it.tag, {{(W-1){1'b0}}, carry},
          {{(W-1){1'b0}}, gen | (prop & it.c0)});
    end
  end

  initial begin
    a = '0; b = '0; c0 = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    drive(16'h0000, 16'h0000, 1'b0, "zero");
    // R6 full-length propagate chains
    drive(16'hFFFF, 16'h0000, 1'b1, "R6 cin chain");
    drive(16'hFFFF, 16'h0001, 1'b0, "R6 b chain");
    drive(16'hFFFF, 16'hFFFF, 1'b1, "R6 all ones");
    drive(16'hFFFF, 16'h0000, 1'b0, "R6 prop no carry");
    // R7 slice boundary crossings
    drive(16'h000F, 16'h0001, 1'b0, "R7 slice0");
    drive(16'h00FF, 16'h0001, 1'b0, "R7 slice1");
    drive(16'h0FFF, 16'h0001, 1'b0, "R7 slice2");
    drive(16'h7FFF, 16'h0001, 1'b0, "R7 slice3");
    drive(16'h0FF0, 16'h0010, 1'b0, "R7 mid gen");
    drive(16'h8000, 16'h8000, 1'b0, "R4 top gen");
    drive(16'h5555, 16'hAAAA, 1'b1, "R3 alt prop");
    for (int n = 0; n < 3000; n++) begin
      drive(W'($urandom), W'($urandom), 1'($urandom), "random");
    end
    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R1 [drain] actual=%0d expected=0", q.size());
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule